// File: doc/BRIEF.md
# Energy Dispersal Descrambler

This block removes the energy-dispersal randomisation from transport packets after block-code correction. Bytes come in on a valid/ready stream with two flags from the sync controller: one marks the first byte of a packet, and one says that this first byte is the inverted sync value. A packet that starts inverted opens a new randomisation period. The period normally holds eight packets. A 15-stage PRBS generator is reloaded with a fixed seed at each period start. Every payload byte is XORed with the next eight generator bits. The sync bytes of the other packets let the generator run without being changed.

The stream may carry 188-byte packets, with the parity already stripped, or 204-byte packets that still hold their 16 parity bytes. In the 204-byte mode the parity bytes pass through untouched and the generator does not advance during them. A bypass pin passes every byte through unmodified.

Back-pressure: a byte is transferred on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being emptied in the same cycle. Once `m_valid` is high, the output holds its data and flags until `m_ready` takes them. The input side may drop `s_valid` between bytes at any time.

Top module: `edd_descrambler`

## Requirements
- R1: After reset `m_valid` is low, `s_ready` is high, and the generator holds the seed. With stages 1 to 15 listed in order, the seed is 1,0,0,1,0,1,0,1,0,0,0,0,0,0,0.
- R2: A transferred byte with `s_sop=1` and `s_inv=1` (bypass off) comes out as 0x47, whatever its input value, and reloads the generator with the seed.
- R3: The generator output bit is stage 14 XOR stage 15. This bit is shifted into stage 1 as every other stage moves up by one. Each byte uses eight output bits, and the first bit goes to data bit 7. The first payload byte after a reload is therefore XORed with 0x03.
- R4: Each transferred payload byte (`s_sop=0`, outside the parity region) leaves as the input XOR the next eight generator bits.
- R5: A transferred byte with `s_sop=1` and `s_inv=0` leaves unchanged, and the generator advances eight steps during it.
- R6: With `frame204=1`, the bytes at positions 188 to 203 after a packet start (where the start is position 0) leave unchanged, and the generator holds during them. With `frame204=0` there is no parity region.
- R7: With `bypass=1`, every byte leaves unchanged. Generator updates continue exactly as they would with bypass off.
- R8: While `m_valid=1` and `m_ready=0`, the outputs stay stable on the next cycle, and `s_ready` is low.
- R9: A byte transferred in on one edge appears on `m_data` with `m_valid=1` after that edge, with `m_sop` equal to its `s_sop`. Bytes leave in arrival order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1: pass bytes through unmodified |
| frame204 | input | 1 | 1: packets carry 16 trailing parity bytes |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can take an input byte |
| s_data | input | 8 | Input byte |
| s_sop | input | 1 | Input byte is a packet's first byte |
| s_inv | input | 1 | With s_sop: packet starts with the inverted sync |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the output byte |
| m_data | output | 8 | Output byte |
| m_sop | output | 1 | Output byte is a packet's first byte |

## Verification
A wrong generator state does not stay hidden: at the next payload byte that leaves, every bit the bad state reaches is flipped. The seed check makes a bad reload show on the first byte after the inverted sync. A position counter that has drifted shows within one packet in the 204-byte mode, either as descrambled parity or as a keystream that has slipped by a byte for the rest of the period. A fault in the handshake shows as a lost, repeated or reordered byte when the very next transfer is compared under random stalls.

// File: rtl/edd_pkg.sv
package edd_pkg;
  localparam int LFSR_W = 15;
  localparam int BYTE_W = 8;
  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // bit i holds stage i+1; stages 1,4,6,8 set
  localparam lfsr_t PRBS_SEED = 15'h00A9;

  typedef struct packed {
    lfsr_t nxt;
    byte_t ks;
  } prbs_step_t;

  // eight shifts; first produced bit lands on bit 7
  function automatic prbs_step_t prbs_byte(input lfsr_t cur);
    prbs_step_t r;
    lfsr_t s;
    logic b;
    s = cur;
    r.ks = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      b = s[13] ^ s[14];
      r.ks[BYTE_W-1-i] = b;
      s = {s[LFSR_W-2:0], b};
    end
    r.nxt = s;
    return r;
  endfunction
endpackage

// File: rtl/edd_prbs.sv
module edd_prbs
  import edd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output byte_t ks
);
  lfsr_t      state;
  prbs_step_t nx;

  always_comb nx = prbs_byte(state);
  assign ks = nx.ks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= PRBS_SEED;
    else if (load) state <= PRBS_SEED;
    else if (step) state <= nx.nxt;
  end
endmodule

// File: rtl/edd_pos.sv
module edd_pos #(
  parameter int PAY_LEN  = 188,
  parameter int FULL_LEN = 204
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic sop,
  input  logic frame204,
  output logic in_parity
);
  localparam int POS_W = $clog2(FULL_LEN + 1);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_PAY = POS_W'(PAY_LEN);

  logic [POS_W-1:0] pos;

  assign in_parity = frame204 && !sop && (pos >= POS_PAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (adv) begin
      if (sop)                pos <= POS_W'(1);
      else if (pos != POS_MAX) pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/edd_outreg.sv
module edd_outreg
  import edd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  i_valid,
  output logic  i_ready,
  input  byte_t i_data,
  input  logic  i_sop,
  output logic  o_valid,
  input  logic  o_ready,
  output byte_t o_data,
  output logic  o_sop
);
  assign i_ready = !o_valid || o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sop   <= 1'b0;
    end else if (i_ready) begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_data <= i_data;
        o_sop  <= i_sop;
      end
    end
  end
endmodule

// File: rtl/edd_descrambler.sv
module edd_descrambler
  import edd_pkg::*;
#(
  parameter int          PAY_LEN   = 188,
  parameter int          FULL_LEN  = 204,
  parameter logic [7:0]  SYNC_NORM = 8'h47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bypass,
  input  logic       frame204,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sop,
  input  logic       s_inv,
  output logic       m_valid,
  input  logic       m_ready,
  output logic [7:0] m_data,
  output logic       m_sop
);
  logic  fire, reload, adv_gen, parity;
  byte_t ks, outb;

  assign fire    = s_valid && s_ready;
  assign reload  = fire && s_sop && s_inv;
  assign adv_gen = fire && !reload && !parity;

  edd_pos #(.PAY_LEN(PAY_LEN), .FULL_LEN(FULL_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(fire), .sop(s_sop),
    .frame204(frame204), .in_parity(parity)
  );

  edd_prbs u_prbs (
    .clk(clk), .rst_n(rst_n), .load(reload), .step(adv_gen), .ks(ks)
  );

  always_comb begin
    if (bypass)              outb = s_data;
    else if (s_sop && s_inv) outb = SYNC_NORM;
    else if (s_sop || parity) outb = s_data;
    else                     outb = s_data ^ ks;
  end

  edd_outreg u_out (
    .clk(clk), .rst_n(rst_n),
    .i_valid(s_valid), .i_ready(s_ready), .i_data(outb), .i_sop(s_sop),
    .o_valid(m_valid), .o_ready(m_ready), .o_data(m_data), .o_sop(m_sop)
  );
endmodule

// File: rtl/edd_descrambler_chk.sv
module edd_descrambler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bypass,
  input logic       s_valid,
  input logic       s_ready,
  input logic [7:0] s_data,
  input logic       s_sop,
  input logic       s_inv,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_sop
);
  logic acc;
  assign acc = s_valid && s_ready;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sop));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  // R9
  transfer_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> m_valid && (m_sop == $past(s_sop)));

  // R2
  sync_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && s_sop && s_inv && !bypass |=> m_data == 8'h47);

  // R5
  plain_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && s_sop && !s_inv |=> m_data == $past(s_data));

  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && bypass |=> m_data == $past(s_data));
endmodule

bind edd_descrambler edd_descrambler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass),
  .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop), .s_inv(s_inv),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop)
);

// File: tb/edd_descrambler_bench.sv
`timescale 1ns/1ps
module edd_descrambler_bench;
  logic clk = 0, rst_n = 0, bypass = 0, frame204 = 0;
  logic s_valid = 0, s_sop = 0, s_inv = 0, m_ready = 0;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_sop;
  logic [7:0] m_data;

  always #2 clk = ~clk;

  edd_descrambler u_edd_descrambler (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .frame204(frame204),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sop(s_sop), .s_inv(s_inv),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sop(m_sop)
  );

  int vectors = 0, miscompares = 0;
  int stall_pct = 0;
  bit done = 0;

  // behavioural reference
  bit gen[1:15];
  int pos = 0;
  bit fresh = 0;
  logic [8:0] q_exp[$];
  string q_tag[$];

  function automatic void check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  function automatic void seed_gen();
    for (int i = 1; i <= 15; i++) gen[i] = 0;
    gen[1] = 1; gen[4] = 1; gen[6] = 1; gen[8] = 1;
  endfunction

  function automatic logic [7:0] next_ks();
    logic [7:0] k;
    for (int i = 7; i >= 0; i--) begin
      bit b;
      b = gen[14] ^ gen[15];
      k[i] = b;
      for (int j = 15; j > 1; j--) gen[j] = gen[j-1];
      gen[1] = b;
    end
    return k;
  endfunction

  function automatic void model(logic [7:0] d, bit sop, bit inv);
    logic [7:0] e, k;
    string t;
    if (sop && inv) begin
      seed_gen();
      pos = 1;
      e = bypass ? d : 8'h47;
      t = bypass ? "R7" : "R2";
      fresh = 1;
    end else if (sop) begin
      pos = 1;
      k = next_ks();
      e = d;
      t = bypass ? "R7" : "R5";
      fresh = 0;
    end else if (frame204 && pos >= 188) begin
      e = d;
      t = bypass ? "R7" : "R6";
      if (pos < 255) pos++;
    end else begin
      k = next_ks();
      if (fresh) check(k == 8'h03, "R3", k, 8'h03);
      e = bypass ? d : (d ^ k);
      t = bypass ? "R7" : (fresh ? "R3" : "R4");
      fresh = 0;
      if (pos < 255) pos++;
    end
    q_exp.push_back({sop, e});
    q_tag.push_back(t);
  endfunction

  // downstream ready pattern
  always @(negedge clk) m_ready <= ($urandom_range(99) >= stall_pct);

  // output compare every clock
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(m_valid == (q_exp.size() != 0), "R9", m_valid, q_exp.size() != 0);
      if (m_valid && !m_ready) check(!s_ready, "R8", s_ready, 0);
      if (m_valid && m_ready && q_exp.size() != 0) begin
        logic [8:0] x;
        string t;
        x = q_exp.pop_front();
        t = q_tag.pop_front();
        check(m_data == x[7:0], t, m_data, x[7:0]);
        check(m_sop == x[8], "R9", m_sop, x[8]);
      end
    end
  end

  task automatic send(logic [7:0] d, bit sop, bit inv);
    @(negedge clk);
    s_valid = 1; s_data = d; s_sop = sop; s_inv = inv;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    model(d, sop, inv);
  endtask

  task automatic packet(bit inv, int len, bit zero_first);
    send(inv ? 8'hB8 : 8'h47, 1, inv);
    for (int i = 1; i < len; i++)
      send((zero_first && i == 1) ? 8'h00 : 8'($urandom), 0, 0);
  endtask

  task automatic period(int len);
    packet(1, len, 1);
    for (int p = 1; p < 8; p++) packet(0, len, 0);
  endtask

  task automatic drain();
    @(negedge clk);
    s_valid = 0; s_sop = 0; s_inv = 0;
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
      begin
        seed_gen();
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(m_valid == 0, "R1", m_valid, 0);
        check(s_ready == 1, "R1", s_ready, 1);
        rst_n = 1;
        // R1: payload before any inverted sync uses the seed
        send(8'h00, 0, 0);
        packet(0, 12, 0);
        period(24);           // 188 mode, R2 R3 R4 R5
        stall_pct = 40;
        period(30);           // under back-pressure, R8
        drain();
        frame204 = 1;
        stall_pct = 20;
        period(204);          // R6 parity bypass of generator
        period(204);
        packet(0, 60, 0);     // short packet then a new start
        drain();
        bypass = 1;           // R7
        period(20);
        drain();
        bypass = 0; frame204 = 0; stall_pct = 0;
        period(16);
        drain();
      end
    join_any
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule